// File: doc/BRIEF.md
# I/O Storage Ordering Barrier Unit

This block sits between an in-order issue stage and a memory access port. It watches the instruction stream for the I/O ordering barrier word. Once it sees that word, it keeps the order of memory accesses that target caching-inhibited or guarded storage. An access of that kind that is issued after the barrier is held back until every access of that kind issued before the barrier has been acknowledged as complete. Accesses to cacheable storage keep flowing and are never ordered by the barrier. The pending store queue is not drained. The barrier is a weaker ordering point than a full synchronisation.

The block keeps a count of outstanding guarded accesses. The count rises when such an access is accepted and falls when a completion acknowledgement arrives. A pending barrier holds only while that count is nonzero. A barrier that arrives while an earlier barrier is still pending merges into it. The stall output is combinational, so the issue stage can hold its request in the same cycle. An accepted request comes out on a registered forwarding port one cycle later. An acknowledgement that arrives with nothing outstanding raises an error pulse.

Top module: `io_order_gate`

## Requirements
- R1: A barrier is recognised only when `insn_valid` is high and `insn_word` equals exactly 0x7c0006ac. In LSB-0 numbering this word is primary opcode 31 in bits 31:26, extended opcode 854 in bits 10:1, and zero in every other bit. Any other word, or the right word with `insn_valid` low, has no effect on later guarded requests.
- R2: While a barrier is pending and guarded accesses are outstanding, a request with `req_guarded`=1 sees `stall`=1 in the same cycle and is not forwarded.
- R3: The stall stays high during the cycle in which the last outstanding acknowledgement arrives. It is low from the next cycle on.
- R4: A request with `req_guarded`=0 never sees `stall`, even while a barrier is pending, and is forwarded.
- R5: A guarded request presented in the same cycle as the barrier word counts as older than the barrier. It is accepted, and the barrier then waits for it.
- R6: Several barriers with no guarded access accepted between them merge into one pending barrier. It is released by the acknowledgements of the accesses that were outstanding before the first of them.
- R7: An acknowledgement that arrives while the outstanding count is zero drives `ack_err` high for one cycle, starting at the next clock edge. The count stays at zero.
- R8: When MAX_OUT guarded accesses are outstanding, a further guarded request is stalled even with no barrier pending. Cacheable requests still pass.
- R9: After reset, no barrier is pending, the count is zero, and `stall`, `fwd_valid` and `ack_err` are low.
- R10: An accepted request shows up on `fwd_valid`/`fwd_guarded`/`fwd_we`/`fwd_addr` one cycle after acceptance, with the same field values.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Issued instruction word |
| req_valid | input | 1 | Memory request present |
| req_guarded | input | 1 | Request targets caching-inhibited or guarded storage |
| req_we | input | 1 | Request is a store |
| req_addr | input | AW | Request address |
| ack_valid | input | 1 | Completion acknowledgement for one guarded access |
| stall | output | 1 | Hold the current request (combinational) |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_guarded | output | 1 | Forwarded attribute flag |
| fwd_we | output | 1 | Forwarded store flag |
| fwd_addr | output | AW | Forwarded address |
| ack_err | output | 1 | Acknowledgement arrived with nothing outstanding |

## Verification
The hardest cases to reach are the ones where events land on the same clock edge. These are a barrier word and a guarded request in one cycle, and a held request that is still present when the final acknowledgement lands. The bench drives each cycle through one step task that can assert the instruction, request and acknowledgement inputs together. This lets it line these events up exactly. It checks the combinational stall just before the edge, and the scoreboard confirms which requests were actually forwarded.

// File: rtl/io_order_pkg.sv
package io_order_pkg;
  localparam int unsigned INSN_W = 32;
  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] EXT_OP     = 10'd854;

  // Barrier encoding: operand fields and record bit all zero.
  function automatic logic [INSN_W-1:0] barrier_encoding();
    return {PRIMARY_OP, 5'd0, 5'd0, 5'd0, EXT_OP, 1'b0};
  endfunction
endpackage

// File: rtl/io_barrier_match.sv
module io_barrier_match
  import io_order_pkg::*;
(
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_word,
  output logic              hit
);
  logic [5:0] f_primary;
  logic [9:0] f_ext;
  logic [14:0] f_operands;
  logic       f_rec;

  assign f_primary  = insn_word[31:26];
  assign f_operands = insn_word[25:11];
  assign f_ext      = insn_word[10:1];
  assign f_rec      = insn_word[0];

  assign hit = insn_valid && (f_primary == PRIMARY_OP) && (f_ext == EXT_OP)
               && (f_operands == '0) && !f_rec;

  always_comb begin
    if (hit) assert_exact_word_R1: assert (insn_word == barrier_encoding());
  end
endmodule

// File: rtl/io_outstanding_ctr.sv
module io_outstanding_ctr #(
  parameter int unsigned MAX_OUT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic zero,
  output logic full,
  output logic ack_err
);
  localparam int unsigned CW = $clog2(MAX_OUT + 1);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_OUT);

  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          dec_ok;

  assign dec_ok  = dec && (cnt_q != '0);
  assign zero    = (cnt_q == '0);
  assign full    = (cnt_q == MAX_C);
  assign ack_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= dec && (cnt_q == '0);
      case ({inc, dec_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    !(full && inc && !dec));
  assert_empty_ack_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (dec && zero) |=> ack_err);
  assert_empty_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (dec && zero && !inc) |=> zero);
endmodule

// File: rtl/io_barrier_track.sv
module io_barrier_track (
  input  logic clk,
  input  logic rst,
  input  logic barrier_hit,
  input  logic drained,
  output logic blocked
);
  logic pending_q;

  assign blocked = pending_q && !drained;

  always_ff @(posedge clk) begin
    if (rst) pending_q <= 1'b0;
    else     pending_q <= barrier_hit || blocked;
  end

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (drained && !barrier_hit) |=> !pending_q);
  assert_merge_R6: assert property (@(posedge clk) disable iff (rst)
    barrier_hit |=> pending_q);
endmodule

// File: rtl/io_req_stage.sv
module io_req_stage #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          guarded,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic          fwd_valid,
  output logic          fwd_guarded,
  output logic          fwd_we,
  output logic [AW-1:0] fwd_addr
);
  always_ff @(posedge clk) begin
    if (rst) fwd_valid <= 1'b0;
    else     fwd_valid <= acc;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      fwd_guarded <= guarded;
      fwd_we      <= we;
      fwd_addr    <= addr;
    end
  end

  assert_fwd_follows_R10: assert property (@(posedge clk) disable iff (rst)
    acc |=> (fwd_valid && fwd_addr == $past(addr) && fwd_guarded == $past(guarded)));
endmodule

// File: rtl/io_order_gate.sv
module io_order_gate
  import io_order_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned MAX_OUT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              req_valid,
  input  logic              req_guarded,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic              ack_valid,
  output logic              stall,
  output logic              fwd_valid,
  output logic              fwd_guarded,
  output logic              fwd_we,
  output logic [AW-1:0]     fwd_addr,
  output logic              ack_err
);
  logic hit, blocked, zero, full, acc, inc;

  io_barrier_match u_match (
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .hit        (hit)
  );

  io_outstanding_ctr #(.MAX_OUT(MAX_OUT)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc),
    .dec     (ack_valid),
    .zero    (zero),
    .full    (full),
    .ack_err (ack_err)
  );

  io_barrier_track u_track (
    .clk         (clk),
    .rst         (rst),
    .barrier_hit (hit),
    .drained     (zero),
    .blocked     (blocked)
  );

  assign stall = req_valid && req_guarded && (blocked || full);
  assign acc   = req_valid && !stall;
  assign inc   = acc && req_guarded;

  io_req_stage #(.AW(AW)) u_stage (
    .clk         (clk),
    .rst         (rst),
    .acc         (acc),
    .guarded     (req_guarded),
    .we          (req_we),
    .addr        (req_addr),
    .fwd_valid   (fwd_valid),
    .fwd_guarded (fwd_guarded),
    .fwd_we      (fwd_we),
    .fwd_addr    (fwd_addr)
  );

  assert_cacheable_free_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_guarded) |-> !stall);
  assert_held_not_sent_R2: assert property (@(posedge clk) disable iff (rst)
    stall |=> !fwd_valid);
endmodule

// File: tb/test_io_order_gate.sv
module test_io_order_gate;
  localparam int AW = 16;
  localparam int MAX_OUT = 4;
  localparam logic [31:0] BAR = 32'h7c0006ac;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic req_valid = 1'b0, req_guarded = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic ack_valid = 1'b0;
  logic stall, fwd_valid, fwd_guarded, fwd_we, ack_err;
  logic [AW-1:0] fwd_addr;

  int checks = 0;
  int errors = 0;
  logic [AW+1:0] exp_q[$];
  logic [AW-1:0] next_addr = 16'h0100;
  logic last_err;

  always #5 clk = ~clk;

  io_order_gate #(.AW(AW), .MAX_OUT(MAX_OUT)) i_io_order_gate (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .req_valid(req_valid), .req_guarded(req_guarded), .req_we(req_we),
    .req_addr(req_addr), .ack_valid(ack_valid), .stall(stall),
    .fwd_valid(fwd_valid), .fwd_guarded(fwd_guarded), .fwd_we(fwd_we),
    .fwd_addr(fwd_addr), .ack_err(ack_err)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; checks stall before the edge when a request is driven.
  task automatic step(input logic do_req, input logic g, input logic bv,
                      input logic [31:0] w, input logic ak, input logic exp_stall,
                      input string tag);
    @(negedge clk);
    req_valid   = do_req;
    req_guarded = g;
    req_we      = next_addr[0];
    req_addr    = next_addr;
    insn_valid  = bv;
    insn_word   = w;
    ack_valid   = ak;
    #4;
    if (do_req) begin
      chk(stall == exp_stall, tag, stall, exp_stall);
      if (!stall) exp_q.push_back({g, next_addr[0], next_addr});
      next_addr = next_addr + 1'b1;
    end
    @(posedge clk);
    #1;
    last_err    = ack_err;
    req_valid   = 1'b0;
    insn_valid  = 1'b0;
    ack_valid   = 1'b0;
  endtask

  // Scoreboard monitor: every forwarded item must match the oldest expected one (R10).
  always @(posedge clk) begin
    #1;
    if (!rst && fwd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected forward", fwd_addr, 0);
      end else begin
        logic [AW+1:0] e;
        e = exp_q.pop_front();
        chk({fwd_guarded, fwd_we, fwd_addr} == e, "R10 forwarded fields",
            {fwd_guarded, fwd_we, fwd_addr}, e);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(stall == 0, "R9 stall after reset", stall, 0);
    chk(fwd_valid == 0, "R9 fwd_valid after reset", fwd_valid, 0);
    chk(ack_err == 0, "R9 ack_err after reset", ack_err, 0);

    // R4 / R10: cacheable request flows
    step(1, 0, 0, 0, 0, 0, "R4 cacheable accepted");

    // R1: near-miss words and invalid barrier leave guarded traffic free
    step(1, 1, 0, 0, 0, 0, "R1 setup guarded");
    step(0, 0, 1, 32'h7c0006ad, 0, 0, "");
    step(1, 1, 0, 0, 0, 0, "R1 record bit set is not barrier");
    step(0, 0, 1, 32'h7c0004ac, 0, 0, "");
    step(1, 1, 0, 0, 0, 0, "R1 other extended opcode not barrier");
    step(0, 0, 0, BAR, 0, 0, "");
    step(1, 1, 0, 0, 0, 0, "R1 invalid flag low not barrier");
    repeat (4) step(0, 0, 0, 0, 1, 0, "");

    // R2 / R3 / R4: ordering across one barrier
    step(1, 1, 0, 0, 0, 0, "R2 older guarded accepted");
    step(0, 0, 1, BAR, 0, 0, "");
    step(1, 1, 0, 0, 0, 1, "R2 younger guarded stalled");
    step(1, 0, 0, 0, 0, 0, "R4 cacheable bypasses pending barrier");
    step(1, 1, 0, 0, 1, 1, "R3 stall held in ack cycle");
    step(1, 1, 0, 0, 0, 0, "R3 stall released after ack");
    step(0, 0, 0, 0, 1, 0, "");

    // R5: same-cycle barrier and guarded request
    step(1, 1, 1, BAR, 0, 0, "R5 same-cycle request is older");
    step(1, 1, 0, 0, 0, 1, "R5 barrier waits for same-cycle request");
    step(0, 0, 0, 0, 1, 0, "");
    step(1, 1, 0, 0, 0, 0, "R5 released after its ack");
    step(0, 0, 0, 0, 1, 0, "");

    // R6: merged barriers
    step(1, 1, 0, 0, 0, 0, "R6 setup guarded");
    step(0, 0, 1, BAR, 0, 0, "");
    step(0, 0, 1, BAR, 0, 0, "");
    step(1, 1, 0, 0, 1, 1, "R6 stalled behind merged barriers");
    step(1, 1, 0, 0, 0, 0, "R6 one ack releases merged barriers");
    step(0, 0, 0, 0, 1, 0, "");

    // R7: spurious acknowledgement
    step(0, 0, 0, 0, 1, 0, "");
    chk(last_err == 1, "R7 ack_err on empty ack", last_err, 1);
    step(0, 0, 0, 0, 0, 0, "");
    chk(last_err == 0, "R7 ack_err is one cycle", last_err, 0);
    step(0, 0, 1, BAR, 0, 0, "");
    step(1, 1, 0, 0, 0, 0, "R7 count stayed zero");
    step(0, 0, 0, 0, 1, 0, "");
    chk(last_err == 0, "R7 no error on valid ack", last_err, 0);

    // R8: outstanding limit
    for (int i = 0; i < MAX_OUT; i++) step(1, 1, 0, 0, 0, 0, "R8 fill below limit");
    step(1, 1, 0, 0, 0, 1, "R8 guarded stalled at limit");
    step(1, 0, 0, 0, 0, 0, "R8 cacheable passes at limit");
    step(0, 0, 0, 0, 1, 0, "");
    step(1, 1, 0, 0, 0, 0, "R8 room after one ack");
    repeat (MAX_OUT) step(0, 0, 0, 0, 1, 0, "");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all accepted requests forwarded", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule